// File: doc/BRIEF.md
# Four-Channel Register-Mapped PWM Controller

This block produces four independent pulse-width modulated outputs and is configured through a small 32-bit memory-mapped register port with separate write and read strobes. Each channel has a 16-bit period count, a 16-bit duty count and a 6-bit clock divider. All four dividers share one register. A single control word carries, for every channel, a run bit, an output-sense bit and an output-type bit. The type bits leave the block on their own port so that pad logic outside can use them.

A channel's counter advances once every (divider+1) clocks and wraps after the period count, so a full cycle lasts (divider+1)*period clocks. The output is active while the counter is below the duty count. Period, duty and divider values are copied into a channel's working copy only when its run bit goes from 0 to 1. Software therefore changes a running channel by clearing its run bit and setting it again. Every stored register value can be read back. Reads return data one clock after the read strobe.

Top module: `pwm_quad`

## Requirements
- R1: Writing the period word for channel ch (offset 0x04+8*ch) or the duty word (offset 0x08+8*ch) stores bits 15:0 of the written data. A read of that offset returns the stored value zero-extended, in `rd_data` on the clock after `rd_en`.
- R2: The divider word at offset 0x24 holds channel ch's 6-bit divider at bit position (3-ch)*6. Channel 0 therefore uses bits 23:18 and channel 3 uses bits 5:0, and each field controls only its own channel.
- R3: Reads of unmapped or unaligned offsets return zero. Unused control bits read as zero, so a control word of all ones reads back as 0x00078F0F. Unused divider bits read as zero, so a divider word of all ones reads back as 0x00FFFFFF.
- R4: The control word at offset 0x00 holds the run bit for channel ch at bit ch. While that bit is 0, the channel's counters are held at zero and its output sits at the inactive level. The inactive level is 1 when the sense bit is 0, and 0 when the sense bit is 1.
- R5: The rising edge of a channel's run bit takes effect on the clock after the control write. On that clock the channel loads its working period, duty and divider and restarts its count at zero. The first output cycle is active when the duty count is nonzero.
- R6: A running channel repeats with a period of (divider+1)*period clocks and is active for (divider+1)*min(duty,period) clocks of each period. The smallest meaningful period count is 2.
- R7: A duty count of 0 keeps the output inactive for the whole period. A duty count equal to or larger than the period count keeps it active for the whole period.
- R8: The sense bit for channel ch is control bit 8+ch. With a 1 the active level is high; with a 0 the output is inverted.
- R9: Writes to period, duty or divider while a channel runs are stored and read back at once. They leave the running waveform unchanged until the next rising edge of the run bit.
- R10: The output-type bit for channel ch is control bit 15+ch and appears directly on `drv_mode[ch]`. A 0 selects full drive.
- R11: After reset all registers read as zero, all outputs are 1 (inactive for sense 0) and `drv_mode` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, data appears on the next clock |
| addr | input | 8 | Byte offset of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, held until the next read |
| pwm_out | output | 4 | One PWM output per channel |
| drv_mode | output | 4 | Output-type bit per channel |

## Verification
The bench uses the default parameters: four channels, 16-bit counts and 6-bit dividers. This keeps the address map exactly as the requirements state, including the reversed divider packing. Waveform checks use short periods of 2 to 6 counts with small dividers, so each measurement window of two complete periods fits in a few dozen clocks. These windows still cover minimum period, zero duty, duty beyond period, inverted sense and the deferred-update behaviour. Register checks write all-ones patterns to show the masking of unused bits.

// File: rtl/pwm_quad_pkg.sv
`timescale 1ns/1ps
package pwm_quad_pkg;

  localparam int NCH       = 4;
  localparam int CNT_W     = 16;
  localparam int PRE_W     = 6;
  localparam int AW        = 8;
  localparam int DW        = 32;
  localparam int POL_BASE  = 8;
  localparam int TYPE_BASE = 15;

  localparam logic [AW-1:0] OFS_CTRL = 8'h00;
  localparam logic [AW-1:0] OFS_DIV  = 8'h24;

  typedef enum logic [2:0] {
    RK_CTRL,
    RK_PER,
    RK_DUTY,
    RK_DIV,
    RK_NONE
  } reg_kind_t;

  function automatic logic [AW-1:0] ofs_period(input int ch);
    return AW'(4 + 8 * ch);
  endfunction

  function automatic logic [AW-1:0] ofs_duty(input int ch);
    return AW'(8 + 8 * ch);
  endfunction

endpackage

// File: rtl/pwm_regbank.sv
`timescale 1ns/1ps
module pwm_regbank
  import pwm_quad_pkg::*;
#(
  parameter int N_CH   = NCH,
  parameter int C_W    = CNT_W,
  parameter int P_W    = PRE_W,
  parameter int A_W    = AW,
  parameter int D_W    = DW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [A_W-1:0]            addr,
  input  logic [D_W-1:0]            wr_data,
  output logic [D_W-1:0]            rd_data,
  output logic [N_CH-1:0]           run_o,
  output logic [N_CH-1:0]           sense_o,
  output logic [N_CH-1:0]           type_o,
  output logic [N_CH-1:0][C_W-1:0]  period_o,
  output logic [N_CH-1:0][C_W-1:0]  duty_o,
  output logic [N_CH-1:0][P_W-1:0]  div_o
);

  localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [N_CH-1:0]          run_q, run_d;
  logic [N_CH-1:0]          sense_q, sense_d;
  logic [N_CH-1:0]          type_q, type_d;
  logic [N_CH-1:0][C_W-1:0] per_q, per_d;
  logic [N_CH-1:0][C_W-1:0] duty_q, duty_d;
  logic [N_CH-1:0][P_W-1:0] div_q, div_d;
  logic [D_W-1:0]           rdata_q, rdata_d;
  logic [D_W-1:0]           rd_word;
  reg_kind_t                kind;
  logic [SEL_W-1:0]         sel;

  // address decode
  always_comb begin
    kind = RK_NONE;
    sel  = '0;
    if (addr == A_W'(OFS_CTRL)) begin
      kind = RK_CTRL;
    end else if (addr == A_W'(OFS_DIV)) begin
      kind = RK_DIV;
    end else begin
      for (int ch = 0; ch < N_CH; ch++) begin
        if (addr == A_W'(ofs_period(ch))) begin
          kind = RK_PER;
          sel  = SEL_W'(ch);
        end
        if (addr == A_W'(ofs_duty(ch))) begin
          kind = RK_DUTY;
          sel  = SEL_W'(ch);
        end
      end
    end
  end

  // next state of the stored registers
  always_comb begin
    run_d   = run_q;
    sense_d = sense_q;
    type_d  = type_q;
    per_d   = per_q;
    duty_d  = duty_q;
    div_d   = div_q;
    if (wr_en) begin
      unique case (kind)
        RK_CTRL: begin
          for (int ch = 0; ch < N_CH; ch++) begin
            run_d[ch]   = wr_data[ch];
            sense_d[ch] = wr_data[POL_BASE + ch];
            type_d[ch]  = wr_data[TYPE_BASE + ch];
          end
        end
        RK_PER:  per_d[sel]  = wr_data[C_W-1:0];
        RK_DUTY: duty_d[sel] = wr_data[C_W-1:0];
        RK_DIV: begin
          // field order is reversed: channel 0 sits highest
          for (int ch = 0; ch < N_CH; ch++) begin
            div_d[ch] = wr_data[(N_CH-1-ch)*P_W +: P_W];
          end
        end
        default: ;
      endcase
    end
  end

  // read multiplexer
  always_comb begin
    rd_word = '0;
    unique case (kind)
      RK_CTRL: begin
        for (int ch = 0; ch < N_CH; ch++) begin
          rd_word[ch]             = run_q[ch];
          rd_word[POL_BASE + ch]  = sense_q[ch];
          rd_word[TYPE_BASE + ch] = type_q[ch];
        end
      end
      RK_PER:  rd_word[C_W-1:0] = per_q[sel];
      RK_DUTY: rd_word[C_W-1:0] = duty_q[sel];
      RK_DIV: begin
        for (int ch = 0; ch < N_CH; ch++) begin
          rd_word[(N_CH-1-ch)*P_W +: P_W] = div_q[ch];
        end
      end
      default: rd_word = '0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      sense_q <= '0;
      type_q  <= '0;
      per_q   <= '0;
      duty_q  <= '0;
      div_q   <= '0;
      rdata_q <= '0;
    end else begin
      run_q   <= run_d;
      sense_q <= sense_d;
      type_q  <= type_d;
      per_q   <= per_d;
      duty_q  <= duty_d;
      div_q   <= div_d;
      rdata_q <= rdata_d;
    end
  end

  assign rd_data  = rdata_q;
  assign run_o    = run_q;
  assign sense_o  = sense_q;
  assign type_o   = type_q;
  assign period_o = per_q;
  assign duty_o   = duty_q;
  assign div_o    = div_q;

  // R3: an unmapped read yields zero on the following clock
  a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && kind == RK_NONE) |=> (rd_data == '0));

  // R1: a read without a simultaneous write of the same word returns the stored period
  a_r1_period_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && kind == RK_PER) |=> (rd_data[C_W-1:0] == per_q[$past(sel)]));

endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import pwm_quad_pkg::*;
#(
  parameter int C_W = CNT_W,
  parameter int P_W = PRE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           sense_i,
  input  logic [C_W-1:0] period_i,
  input  logic [C_W-1:0] duty_i,
  input  logic [P_W-1:0] div_i,
  output logic           pwm_o
);

  logic           live_q, live_d;
  logic [C_W-1:0] cnt_q, cnt_d;
  logic [P_W-1:0] pre_q, pre_d;
  logic [C_W-1:0] wper_q, wduty_q;
  logic [P_W-1:0] wdiv_q;
  logic           load;
  logic           tick;
  logic [C_W:0]   cnt_inc;
  logic           active;

  assign load    = run_i && !live_q;
  assign tick    = live_q && (pre_q == wdiv_q);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    live_d = live_q;
    cnt_d  = cnt_q;
    pre_d  = pre_q;
    if (!run_i) begin
      live_d = 1'b0;
      cnt_d  = '0;
      pre_d  = '0;
    end else if (load) begin
      live_d = 1'b1;
      cnt_d  = '0;
      pre_d  = '0;
    end else if (tick) begin
      pre_d = '0;
      cnt_d = (cnt_inc >= {1'b0, wper_q}) ? '0 : cnt_inc[C_W-1:0];
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      cnt_q  <= '0;
      pre_q  <= '0;
    end else begin
      live_q <= live_d;
      cnt_q  <= cnt_d;
      pre_q  <= pre_d;
    end
  end

  // working copy, clock-enabled by the run rising edge only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wper_q  <= '0;
      wduty_q <= '0;
      wdiv_q  <= '0;
    end else if (load) begin
      wper_q  <= period_i;
      wduty_q <= duty_i;
      wdiv_q  <= div_i;
    end
  end

  assign active = (cnt_q < wduty_q);
  assign pwm_o  = live_q ? (sense_i ? active : !active) : !sense_i;

  // R4: a cleared run bit forces both counters to zero on the next clock
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0 && pre_q == '0 && !live_q));

  // R5: a run rising edge restarts the channel from zero
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !live_q) |=> (live_q && cnt_q == '0 && pre_q == '0));

  // R6: the count stays below the working period
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && wper_q >= C_W'(2)) |-> (cnt_q < wper_q));

  // R6: the divider counter never passes the working divider
  a_r6_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (pre_q <= wdiv_q));

  // R9: the working copy is frozen while the channel keeps running
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && run_i) |=> ($stable(wper_q) && $stable(wduty_q) && $stable(wdiv_q)));

endmodule

// File: rtl/pwm_quad.sv
`timescale 1ns/1ps
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int N_CH = NCH,
  parameter int C_W  = CNT_W,
  parameter int P_W  = PRE_W,
  parameter int A_W  = AW,
  parameter int D_W  = DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [A_W-1:0]  addr,
  input  logic [D_W-1:0]  wr_data,
  output logic [D_W-1:0]  rd_data,
  output logic [N_CH-1:0] pwm_out,
  output logic [N_CH-1:0] drv_mode
);

  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  logic [N_CH-1:0]          run;
  logic [N_CH-1:0]          sense;
  logic [N_CH-1:0][C_W-1:0] period;
  logic [N_CH-1:0][C_W-1:0] duty;
  logic [N_CH-1:0][P_W-1:0] divv;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwm_regbank #(
    .N_CH (N_CH),
    .C_W  (C_W),
    .P_W  (P_W),
    .A_W  (A_W),
    .D_W  (D_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .run_o    (run),
    .sense_o  (sense),
    .type_o   (drv_mode),
    .period_o (period),
    .duty_o   (duty),
    .div_o    (divv)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    pwm_channel #(
      .C_W (C_W),
      .P_W (P_W)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .run_i    (run[ch]),
      .sense_i  (sense[ch]),
      .period_i (period[ch]),
      .duty_i   (duty[ch]),
      .div_i    (divv[ch]),
      .pwm_o    (pwm_out[ch])
    );
  end

  // R11: while the internal reset is held, all outputs sit high
  a_r11_reset_level: assert property (@(posedge clk)
    !rst_int_n |-> (pwm_out == '1 && drv_mode == '0));

endmodule

// File: tb/tb_pwm_quad.sv
`timescale 1ns/1ps
module tb_pwm_quad;
  import pwm_quad_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  pwm_out;
  logic [3:0]  drv_mode;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwm_quad dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out), .drv_mode(drv_mode)
  );

  // {channel, divider, period, duty, sense}
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{0, 0, 4, 1, 1},
    '{1, 1, 5, 2, 1},
    '{2, 2, 3, 3, 1},
    '{3, 0, 6, 0, 1},
    '{0, 0, 4, 9, 0},
    '{1, 3, 2, 1, 0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic measure(input int ch, input int total, output int highs, output logic first);
    highs = 0;
    first = 1'b0;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      if (i == 0) first = pwm_out[ch];
      if (pwm_out[ch]) highs++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int          h;
    logic        f;
    wr_en = 0; rd_en = 0; addr = 0; wr_data = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 outputs in reset", {28'd0, pwm_out}, 32'hF);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    check("R11 outputs after reset", {28'd0, pwm_out}, 32'hF);
    check("R11 drv_mode after reset", {28'd0, drv_mode}, 32'h0);
    rd(OFS_CTRL, d);      check("R11 control reads zero", d, 32'h0);
    rd(ofs_period(2), d); check("R11 period reads zero", d, 32'h0);
    rd(OFS_DIV, d);       check("R11 divider reads zero", d, 32'h0);

    // register readback
    wr(ofs_period(1), 32'h1234_ABCD);
    rd(ofs_period(1), d); check("R1 period ch1 low half", d, 32'h0000_ABCD);
    wr(ofs_duty(3), 32'hFFFF_0055);
    rd(ofs_duty(3), d);   check("R1 duty ch3 low half", d, 32'h0000_0055);

    // masking, unmapped, type bits
    wr(OFS_CTRL, 32'hFFFF_FFFF);
    rd(OFS_CTRL, d);      check("R3 control unused bits", d, 32'h0007_8F0F);
    check("R10 drv_mode all set", {28'd0, drv_mode}, 32'hF);
    wr(OFS_CTRL, 32'h0);
    wr(OFS_DIV, 32'hFFFF_FFFF);
    rd(OFS_DIV, d);       check("R3 divider unused bits", d, 32'h00FF_FFFF);
    wr(OFS_DIV, 32'h00FC_0001);
    rd(OFS_DIV, d);       check("R2 divider packing readback", d, 32'h00FC_0001);
    rd(8'h28, d);         check("R3 unmapped 0x28", d, 32'h0);
    rd(8'h02, d);         check("R3 unaligned 0x02", d, 32'h0);
    wr(OFS_CTRL, 32'h5 << TYPE_BASE);
    check("R10 drv_mode pattern 0101", {28'd0, drv_mode}, 32'h5);
    wr(OFS_CTRL, 32'h0);

    // table of waveform vectors
    for (int v = 0; v < NV; v++) begin
      int ch, dv, pr, du, sn, total, act, exp_h;
      ch = VEC[v][0]; dv = VEC[v][1]; pr = VEC[v][2]; du = VEC[v][3]; sn = VEC[v][4];
      total = 2 * (dv + 1) * pr;
      act   = 2 * (dv + 1) * ((du < pr) ? du : pr);
      exp_h = sn ? act : total - act;
      wr(OFS_CTRL, 32'h0);
      wr(ofs_period(ch), pr);
      wr(ofs_duty(ch), du);
      wr(OFS_DIV, 32'(dv) << ((3 - ch) * 6));
      wr(OFS_CTRL, (32'h1 << ch) | (32'(sn) << (POL_BASE + ch)));
      measure(ch, total, h, f);
      check($sformatf("R6 R7 R8 high cycles vec%0d", v), h, exp_h);
      check($sformatf("R5 first cycle vec%0d", v), {31'd0, f}, {31'd0, (du > 0) ~^ (sn != 0)});
      check($sformatf("R4 idle channels vec%0d", v), {28'd0, pwm_out & ~(4'h1 << ch)},
            {28'd0, ~(4'h1 << ch)});
    end

    // divider field of channel 0 at bits 23:18, minimum period
    wr(OFS_CTRL, 32'h0);
    wr(ofs_period(0), 2);
    wr(ofs_duty(0), 1);
    wr(OFS_DIV, 32'h1 << 18);
    wr(OFS_CTRL, 32'h1 | (32'h1 << POL_BASE));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check($sformatf("R2 R6 ch0 divider 1 sample%0d", i), {31'd0, pwm_out[0]},
            {31'd0, (i < 2)});
    end

    // deferred update while running
    wr(OFS_CTRL, 32'h0);
    wr(OFS_DIV, 32'h0);
    wr(ofs_period(0), 4);
    wr(ofs_duty(0), 1);
    wr(OFS_CTRL, 32'h1 | (32'h1 << POL_BASE));
    wr(ofs_duty(0), 3);
    measure(0, 8, h, f);
    check("R9 running waveform unchanged", h, 2);
    rd(ofs_duty(0), d);
    check("R9 new duty readable", d, 32'h3);
    wr(OFS_CTRL, 32'h1 << POL_BASE);
    wr(OFS_CTRL, 32'h1 | (32'h1 << POL_BASE));
    measure(0, 8, h, f);
    check("R9 new duty after re-enable", h, 6);

    // disabled with normal sense: inactive low
    wr(OFS_CTRL, 32'h1 << POL_BASE);
    @(negedge clk);
    check("R4 disabled normal sense low", {31'd0, pwm_out[0]}, 32'h0);
    repeat (5) @(negedge clk);
    check("R4 disabled stays low", {31'd0, pwm_out[0]}, 32'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule